// File: doc/BRIEF.md
# Prioritized Interrupt Autovector Unit

This block gathers many interrupt sources into two shared interrupt lines for a small microcontroller. The sources are split into two groups. The first group has 32 vector slots, and 27 of them can be used. The second group has 14 slots. Each source sends a one-cycle request pulse, and that pulse sets a pending bit. Software clears a pending bit by writing a one to it. A per-source enable bit decides whether a pending bit can raise its group's line and whether it can take part in priority selection.

When the CPU takes a group's interrupt, it jumps to a fixed entry address: 0x0043 for the first group and 0x0053 for the second. At that address it finds a jump instruction. Firmware places the handler page byte in memory at 0x0044 or 0x0054. When autovectoring is on for a group and the CPU fetches the low address byte of that jump (0x0045 or 0x0055), the block replaces the memory byte with a vector byte. The vector byte is computed from the highest-priority pending and enabled source. A single jump-table page can therefore dispatch to a separate routine for each source without any polling. In the first group, vectors run from 0x00 to 0x7C in steps of 4. In the second group they run from 0x80 to 0xB4 in steps of 4.

Top module: `avec_unit`

## Requirements
- R1: After reset every pending bit is clear and both `irq_a` and `irq_b` are low.
- R2: A one-cycle request on a usable slot sets its pending bit at that clock edge. The group's interrupt line is high from the next cycle for as long as the bit is pending and enabled.
- R3: A pending bit whose enable is low does not raise the line and is not chosen as the winner. The bit stays latched, so setting the enable later raises the line in the same cycle without a new request.
- R4: When `clr_we_x` is high, every bit set in `clr_data_x` clears its pending bit at the clock edge. Bits written as zero keep their state.
- R5: If a request and a clear hit the same bit in the same cycle, the bit ends up pending.
- R6: First-group slots 5, 7, 17, 26 and 27 are reserved. A request on one of them never sets a pending bit and never raises `irq_a`.
- R7: A group's vector comes from the lowest-numbered source that is both pending and enabled. For the first group the vector is 4 × index (0x00 to 0x7C). For the second group it is 0x80 + 4 × index (0x80 to 0xB4).
- R8: When `code_fetch` is high, `av_en_a` is high and the address is 0x0045, `fetch_rdata` returns the first-group vector. When `code_fetch` is high, `av_en_b` is high and the address is 0x0055, it returns the second-group vector.
- R9: In every other case, `fetch_rdata` equals `mem_rdata`. This covers autovectoring being off for the addressed group, any other address (including 0x0044 and 0x0054), and any access with `code_fetch` low.
- R10: When a group has no source that is both pending and enabled, its vector is the group base: 0x00 for the first group and 0x80 for the second.
- R11: The two groups are independent. Requests, enables and clears of one group never change the other group's line or vector.
- R12: `fetch_rdata` is combinational in the address and the current pending set. A clear takes effect on the vector returned in the cycle after the clear edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_a | input | N_A (32) | First-group request pulses, one per slot |
| en_a | input | N_A (32) | First-group enable bits |
| clr_we_a | input | 1 | First-group clear write strobe |
| clr_data_a | input | N_A (32) | First-group write-one-to-clear data |
| req_b | input | N_B (14) | Second-group request pulses |
| en_b | input | N_B (14) | Second-group enable bits |
| clr_we_b | input | 1 | Second-group clear write strobe |
| clr_data_b | input | N_B (14) | Second-group write-one-to-clear data |
| av_en_a | input | 1 | Autovector enable, first group |
| av_en_b | input | 1 | Autovector enable, second group |
| code_fetch | input | 1 | Current read is an instruction fetch |
| fetch_addr | input | 16 | Read address |
| mem_rdata | input | 8 | Byte returned by program memory |
| irq_a | output | 1 | Shared interrupt line, first group |
| irq_b | output | 1 | Shared interrupt line, second group |
| fetch_rdata | output | 8 | Read data after vector substitution |

## Verification
A request or a clear driven before a rising edge is due at `irq_x` and in the vector during the cycle after that edge, because there is one register stage. The bench therefore drives on the falling edge and checks at the next falling edge. Enable changes and fetch address, data or qualifier changes go through no register, so they are checked one time unit after they are driven, within the same cycle. Priority changes are followed one clear at a time, and the winner is checked in the cycle after each clear edge.

// File: rtl/avec_pkg.sv
package avec_pkg;

    localparam int unsigned VEC_W    = 8;
    localparam int unsigned ADDR_W   = 16;
    localparam int unsigned STEP_SH  = 2;   // vectors spaced by 4

    typedef logic [VEC_W-1:0]  vec_t;
    typedef logic [ADDR_W-1:0] addr_t;

    // Vector byte for a slot index within a group starting at base.
    function automatic vec_t vec_of(input vec_t base, input int unsigned idx);
        vec_t step;
        step = vec_t'(idx << STEP_SH);
        return base + step;
    endfunction

endpackage

// File: rtl/avec_pending.sv
module avec_pending #(
    parameter int unsigned   N    = 32,
    parameter logic [N-1:0]  RSVD = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    input  logic         clr_we,
    input  logic [N-1:0] clr_data,
    output logic [N-1:0] pend
);

    typedef struct packed {
        logic [N-1:0] pend;
    } st_t;

    st_t          st_d;
    st_t          st_q;
    logic [N-1:0] live;
    logic [N-1:0] clr_mask;

    // Per-slot capability: reserved slots can never latch.
    generate
        for (genvar i = 0; i < N; i++) begin : g_slot
            if (RSVD[i]) begin : g_rsvd
                assign live[i] = 1'b0;

                // R6: a reserved slot stays idle even when requested
                p_rsvd_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
                    req[i] |=> !pend[i]);
            end else begin : g_live
                assign live[i] = 1'b1;

                // R2: a request is latched at the edge that samples it
                p_req_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
                    req[i] |=> pend[i]);

                // R3: a latched bit is kept until it is cleared
                p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
                    (pend[i] && !(clr_we && clr_data[i])) |=> pend[i]);

                // R4: a clear without a competing request drops the bit
                p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
                    (clr_we && clr_data[i] && !req[i]) |=> !pend[i]);
            end
        end
    endgenerate

    always_comb begin
        st_d     = st_q;
        clr_mask = clr_we ? clr_data : '0;
        // Set has precedence over clear so that no event is lost.
        st_d.pend = ((st_q.pend & ~clr_mask) | req) & live;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend = st_q.pend;

endmodule

// File: rtl/avec_prio.sv
module avec_prio
    import avec_pkg::*;
#(
    parameter int unsigned N    = 32,
    parameter vec_t        BASE = 8'h00,
    localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     pend,
    input  logic [N-1:0]     en,
    output logic             any,
    output logic [IDX_W-1:0] idx,
    output vec_t             vec
);

    logic [N-1:0] pe;
    logic [N-1:0] grant;
    logic [N:0]   below;

    assign pe       = pend & en;
    assign below[0] = 1'b0;

    // Ripple chain: a slot wins when nothing lower-numbered is live.
    generate
        for (genvar i = 0; i < N; i++) begin : g_chain
            assign grant[i]    = pe[i] & ~below[i];
            assign below[i+1]  = below[i] | pe[i];
        end
    endgenerate

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (grant[i]) begin
                idx = idx | IDX_W'(i);
            end
        end
    end

    assign any = below[N];
    assign vec = vec_of(BASE, int'(idx));

endmodule

// File: rtl/avec_group.sv
module avec_group
    import avec_pkg::*;
#(
    parameter int unsigned  N    = 32,
    parameter logic [N-1:0] RSVD = '0,
    parameter vec_t         BASE = 8'h00,
    localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    input  logic [N-1:0] en,
    input  logic         clr_we,
    input  logic [N-1:0] clr_data,
    output logic         irq,
    output vec_t         vec
);

    logic [N-1:0]     pend;
    logic [N-1:0]     low_mask;
    logic [IDX_W-1:0] idx;
    logic             any;

    avec_pending #(
        .N    (N),
        .RSVD (RSVD)
    ) u_pending (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .clr_we   (clr_we),
        .clr_data (clr_data),
        .pend     (pend)
    );

    avec_prio #(
        .N    (N),
        .BASE (BASE)
    ) u_prio (
        .pend (pend),
        .en   (en),
        .any  (any),
        .idx  (idx),
        .vec  (vec)
    );

    assign irq = any;

    // Independent view of the slots below the chosen index.
    always_comb begin
        low_mask = '0;
        for (int i = 0; i < N; i++) begin
            low_mask[i] = (i < int'(idx));
        end
    end

    // R7: the chosen slot is live and nothing below it is live
    p_win_live_r7: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> (pend[idx] && en[idx]));

    p_win_lowest_r7: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> ((pend & en & low_mask) == '0));

    // R10: with nothing live the base vector is presented
    p_idle_base_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !irq |-> (vec == BASE));

    // R1: the line starts low out of reset
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !irq);

endmodule

// File: rtl/avec_splice.sv
module avec_splice
    import avec_pkg::*;
#(
    parameter int unsigned          NG    = 2,
    parameter logic [NG*ADDR_W-1:0] SLOTS = {16'h0055, 16'h0045}
) (
    input  logic                code_fetch,
    input  addr_t               fetch_addr,
    input  vec_t                mem_rdata,
    input  logic [NG-1:0]       av_en,
    input  logic [NG*VEC_W-1:0] vecs,
    output vec_t                rdata
);

    logic [NG-1:0] hit;
    vec_t          sub;

    generate
        for (genvar g = 0; g < NG; g++) begin : g_slot
            assign hit[g] = code_fetch && av_en[g]
                         && (fetch_addr == SLOTS[g*ADDR_W +: ADDR_W]);
        end
    endgenerate

    always_comb begin
        sub = '0;
        for (int g = 0; g < NG; g++) begin
            if (hit[g]) begin
                sub = sub | vecs[g*VEC_W +: VEC_W];
            end
        end
        rdata = (hit != '0) ? sub : mem_rdata;
    end

endmodule

// File: rtl/avec_unit.sv
module avec_unit
    import avec_pkg::*;
#(
    parameter int unsigned    N_A    = 32,
    parameter int unsigned    N_B    = 14,
    parameter logic [N_A-1:0] RSVD_A = 32'h0C02_00A0,
    parameter logic [N_B-1:0] RSVD_B = '0,
    parameter vec_t           BASE_A = 8'h00,
    parameter vec_t           BASE_B = 8'h80,
    parameter addr_t          SLOT_A = 16'h0045,
    parameter addr_t          SLOT_B = 16'h0055
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N_A-1:0] req_a,
    input  logic [N_A-1:0] en_a,
    input  logic           clr_we_a,
    input  logic [N_A-1:0] clr_data_a,
    input  logic [N_B-1:0] req_b,
    input  logic [N_B-1:0] en_b,
    input  logic           clr_we_b,
    input  logic [N_B-1:0] clr_data_b,
    input  logic           av_en_a,
    input  logic           av_en_b,
    input  logic           code_fetch,
    input  logic [15:0]    fetch_addr,
    input  logic [7:0]     mem_rdata,
    output logic           irq_a,
    output logic           irq_b,
    output logic [7:0]     fetch_rdata
);

    localparam int unsigned NG = 2;

    vec_t vec_a;
    vec_t vec_b;

    avec_group #(
        .N    (N_A),
        .RSVD (RSVD_A),
        .BASE (BASE_A)
    ) u_grp_a (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req_a),
        .en       (en_a),
        .clr_we   (clr_we_a),
        .clr_data (clr_data_a),
        .irq      (irq_a),
        .vec      (vec_a)
    );

    avec_group #(
        .N    (N_B),
        .RSVD (RSVD_B),
        .BASE (BASE_B)
    ) u_grp_b (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req_b),
        .en       (en_b),
        .clr_we   (clr_we_b),
        .clr_data (clr_data_b),
        .irq      (irq_b),
        .vec      (vec_b)
    );

    avec_splice #(
        .NG    (NG),
        .SLOTS ({SLOT_B, SLOT_A})
    ) u_splice (
        .code_fetch (code_fetch),
        .fetch_addr (fetch_addr),
        .mem_rdata  (mem_rdata),
        .av_en      ({av_en_b, av_en_a}),
        .vecs       ({vec_b, vec_a}),
        .rdata      (fetch_rdata)
    );

    // R9: data reads always see memory
    p_data_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !code_fetch |-> (fetch_rdata == mem_rdata));

    // R8: an enabled fetch of the first slot byte yields the group vector
    p_splice_a_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (code_fetch && av_en_a && fetch_addr == SLOT_A) |-> (fetch_rdata == vec_a));

    p_splice_b_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (code_fetch && av_en_b && fetch_addr == SLOT_B) |-> (fetch_rdata == vec_b));

    // R11: a quiet second group stays quiet whatever the first group does
    p_indep_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_b && req_b == '0 && $stable(en_b)) |=> !irq_b);

endmodule

// File: tb/avec_unit_bench.sv
module avec_unit_bench;

    localparam time CLK_PER = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] req_a = '0, en_a = '0, clr_data_a = '0;
    logic [13:0] req_b = '0, en_b = '0, clr_data_b = '0;
    logic        clr_we_a = 1'b0, clr_we_b = 1'b0;
    logic        av_en_a = 1'b0, av_en_b = 1'b0, code_fetch = 1'b0;
    logic [15:0] fetch_addr = '0;
    logic [7:0]  mem_rdata = '0;
    logic        irq_a, irq_b;
    logic [7:0]  fetch_rdata;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PER/2) clk = ~clk;

    avec_unit u_avec_unit (
        .clk(clk), .rst_n(rst_n),
        .req_a(req_a), .en_a(en_a), .clr_we_a(clr_we_a), .clr_data_a(clr_data_a),
        .req_b(req_b), .en_b(en_b), .clr_we_b(clr_we_b), .clr_data_b(clr_data_b),
        .av_en_a(av_en_a), .av_en_b(av_en_b), .code_fetch(code_fetch),
        .fetch_addr(fetch_addr), .mem_rdata(mem_rdata),
        .irq_a(irq_a), .irq_b(irq_b), .fetch_rdata(fetch_rdata)
    );

    task automatic chk(input string rq, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    // Registered stimulus: driven at a falling edge, visible one edge later.
    task automatic pulse_a(input logic [31:0] m);
        req_a = m; @(negedge clk); req_a = '0;
    endtask
    task automatic pulse_b(input logic [13:0] m);
        req_b = m; @(negedge clk); req_b = '0;
    endtask
    task automatic clear_a(input logic [31:0] m);
        clr_we_a = 1'b1; clr_data_a = m; @(negedge clk); clr_we_a = 1'b0; clr_data_a = '0;
    endtask
    task automatic clear_b(input logic [13:0] m);
        clr_we_b = 1'b1; clr_data_b = m; @(negedge clk); clr_we_b = 1'b0; clr_data_b = '0;
    endtask

    // Combinational read: result checked within the same cycle.
    task automatic rd(input logic [15:0] a, input logic [7:0] m, input logic cf,
                      output logic [7:0] d);
        fetch_addr = a; mem_rdata = m; code_fetch = cf; #1; d = fetch_rdata;
    endtask

    task automatic clean();
        clear_a('1); clear_b('1);
        en_a = '0; en_b = '0; av_en_a = 1'b1; av_en_b = 1'b1;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        av_en_a = 1'b1; av_en_b = 1'b1;
        chk("R1", "irq_a after reset", {7'd0, irq_a}, 8'd0);
        chk("R1", "irq_b after reset", {7'd0, irq_b}, 8'd0);
        rd(16'h0045, 8'hEE, 1'b1, d); chk("R10", "idle vector A", d, 8'h00);
        rd(16'h0055, 8'hEE, 1'b1, d); chk("R10", "idle vector B", d, 8'h80);
    endtask

    task automatic t_priority();
        logic [7:0] d;
        en_a = '1;
        pulse_a(32'h0000_0200);
        chk("R2", "irq_a after req 9", {7'd0, irq_a}, 8'd1);
        chk("R11", "irq_b untouched", {7'd0, irq_b}, 8'd0);
        rd(16'h0045, 8'hEE, 1'b1, d); chk("R8", "vector slot 9", d, 8'h24);
        pulse_a(32'h4000_0008);
        rd(16'h0045, 8'hEE, 1'b1, d); chk("R7", "lowest of 3,9,30", d, 8'h0C);
        rd(16'h0055, 8'hEE, 1'b1, d); chk("R11", "B vector unchanged", d, 8'h80);
        clear_a(32'h0000_0008);
        rd(16'h0045, 8'hEE, 1'b1, d); chk("R12", "after clear 3", d, 8'h24);
        clear_a(32'h0000_0200);
        rd(16'h0045, 8'hEE, 1'b1, d); chk("R7", "slot 30 vector", d, 8'h78);
        clear_a(32'h4000_0000);
        chk("R4", "irq_a after last clear", {7'd0, irq_a}, 8'd0);
        rd(16'h0045, 8'hEE, 1'b1, d); chk("R10", "back to base", d, 8'h00);
        clean();
    endtask

    task automatic t_mask();
        logic [7:0] d;
        en_a = '0;
        pulse_a(32'h0000_0004);
        chk("R3", "masked irq_a", {7'd0, irq_a}, 8'd0);
        rd(16'h0045, 8'hEE, 1'b1, d); chk("R3", "masked not chosen", d, 8'h00);
        en_a = 32'h0000_0004; #1;
        chk("R3", "irq_a on enable", {7'd0, irq_a}, 8'd1);
        rd(16'h0045, 8'hEE, 1'b1, d); chk("R3", "vector on enable", d, 8'h08);
        en_a = 32'h0000_0010;
        pulse_a(32'h0000_0010);
        rd(16'h0045, 8'hEE, 1'b1, d); chk("R3", "masked lower skipped", d, 8'h10);
        clean();
    endtask

    task automatic t_partial_clear();
        logic [7:0] d;
        en_a = '1;
        pulse_a(32'h0000_0042);
        clear_a(32'h0000_0002);
        chk("R4", "irq_a kept by slot 6", {7'd0, irq_a}, 8'd1);
        rd(16'h0045, 8'hEE, 1'b1, d); chk("R4", "zero bits kept", d, 8'h18);
        clean();
    endtask

    task automatic t_same_cycle();
        logic [7:0] d;
        en_a = '1;
        pulse_a(32'h0000_1000);
        req_a = 32'h0000_1000; clr_we_a = 1'b1; clr_data_a = 32'h0000_1000;
        @(negedge clk);
        req_a = '0; clr_we_a = 1'b0; clr_data_a = '0;
        chk("R5", "irq_a set wins", {7'd0, irq_a}, 8'd1);
        rd(16'h0045, 8'hEE, 1'b1, d); chk("R5", "slot 12 pending", d, 8'h30);
        clean();
    endtask

    task automatic t_reserved();
        logic [7:0] d;
        en_a = '1;
        pulse_a(32'h0C02_00A0);
        chk("R6", "reserved irq_a", {7'd0, irq_a}, 8'd0);
        rd(16'h0045, 8'hEE, 1'b1, d); chk("R6", "reserved vector", d, 8'h00);
        clean();
    endtask

    task automatic t_group_b();
        logic [7:0] d;
        en_b = '1;
        pulse_b(14'h2040);
        chk("R2", "irq_b after req", {7'd0, irq_b}, 8'd1);
        chk("R11", "irq_a untouched", {7'd0, irq_a}, 8'd0);
        rd(16'h0055, 8'hEE, 1'b1, d); chk("R7", "B slot 6", d, 8'h98);
        clear_b(14'h0040);
        rd(16'h0055, 8'hEE, 1'b1, d); chk("R7", "B slot 13", d, 8'hB4);
        rd(16'h0045, 8'hEE, 1'b1, d); chk("R11", "A vector idle", d, 8'h00);
        clean();
    endtask

    task automatic t_passthrough();
        logic [7:0] d;
        en_a = '1; en_b = '1;
        pulse_a(32'h0000_0200); pulse_b(14'h0004);
        av_en_a = 1'b0;
        rd(16'h0045, 8'h5A, 1'b1, d); chk("R9", "A autovector off", d, 8'h5A);
        rd(16'h0055, 8'h11, 1'b1, d); chk("R8", "B still spliced", d, 8'h88);
        av_en_a = 1'b1; av_en_b = 1'b0;
        rd(16'h0055, 8'h33, 1'b1, d); chk("R9", "B autovector off", d, 8'h33);
        av_en_b = 1'b1;
        rd(16'h0044, 8'hC3, 1'b1, d); chk("R9", "page byte A", d, 8'hC3);
        rd(16'h0054, 8'hC4, 1'b1, d); chk("R9", "page byte B", d, 8'hC4);
        rd(16'h0043, 8'h02, 1'b1, d); chk("R9", "jump opcode", d, 8'h02);
        rd(16'h0045, 8'h77, 1'b0, d); chk("R9", "data read of slot", d, 8'h77);
        code_fetch = 1'b0;
        clean();
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_priority();
        t_mask();
        t_partial_clear();
        t_same_cycle();
        t_reserved();
        t_group_b();
        t_passthrough();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog all actual=timeout expected=done");
        finish_run();
    end

endmodule